// File: doc/BRIEF.md
# Batch-Marking Rank-Based Request Scheduler

This block picks, each cycle, one request out of a memory request buffer. It serves the buffer in batches. When no live entry carries a batch mark, it marks a new batch. For every pairing of thread and bank, it marks up to a configurable cap of that pairing's oldest requests. One cycle later it fixes a rank for every thread from the marked load. A thread whose busiest bank holds fewer marked requests ranks higher. A smaller marked total settles ties, and then the lower thread id.

The buffer itself lives outside the block. The block sees each slot as a valid flag, a thread id, a bank id, a row-hit flag, a legal-to-issue flag and an age. A larger age means older by default; a parameter can reverse this. A grant appears in the same cycle as the inputs that cause it. The owner of the buffer reports a finished slot on the completion port, and that clears the slot's mark.

Unmarked requests still go out to banks that hold no marked work. The batch therefore never leaves a free bank idle.

Top module: `batch_rank_sched`

## Requirements
- R1: After reset no entry is marked, no rank table is valid, and `grant_valid` is low while no slot is valid.
- R2: At batch formation, for each (thread, bank) pairing, the `mark_cap` oldest valid entries are marked, or all of them if there are fewer. A larger `ent_age` is older; equal ages treat the lower slot index as older. A slot completing in that cycle takes no part.
- R3: A new batch is formed only in a cycle when no valid entry holds a mark. A request that arrives while a batch is live stays unmarked.
- R4: Thread rank, fixed for the whole batch and applied identically on every bank, follows three keys in order. A lower maximum marked count on any one bank ranks higher. Then a lower total of marked entries ranks higher. Then the lower thread id ranks higher.
- R5: Among candidates the grant goes to the highest key, compared in this order: marked over unmarked, then row hit over miss, then the higher-ranked thread, then the older age. The lowest slot index breaks any remaining tie.
- R6: An unmarked entry is a candidate only when its bank holds no valid marked entry. It may be granted while a batch is live or while ranking is pending.
- R7: The rank table is loaded at the clock edge after the formation edge. In the cycle between those two edges, no marked entry is granted.
- R8: Only entries that are both valid and legal are granted. At most one grant is made per cycle, and `grant_valid`/`grant_idx` reflect the current inputs without a register stage.
- R9: A completion pulse on `done_valid` with slot `done_idx` clears that slot's mark at the next edge. A slot refilled while still valid is then treated as unmarked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_valid | input | ENTRIES | Slot holds a request |
| ent_thread | input | ENTRIES*log2(THREADS) | Thread id per slot, slot 0 in the low bits |
| ent_bank | input | ENTRIES*log2(BANKS) | Bank id per slot |
| ent_rowhit | input | ENTRIES | Request targets the open row of its bank |
| ent_legal | input | ENTRIES | Request may issue this cycle |
| ent_age | input | ENTRIES*AGE_W | Age per slot |
| mark_cap | input | CAP_W | Per thread and bank marking limit |
| done_valid | input | 1 | A slot has completed |
| done_idx | input | log2(ENTRIES) | Slot that completed |
| grant_valid | output | 1 | A request is granted this cycle |
| grant_idx | output | log2(ENTRIES) | Slot granted |

## Verification
A grant is a combinational function of the current inputs and the registered marks and ranks, so it is due in the same cycle as its cause. Marks change at the formation edge and ranks one edge later, so the first marked grant of a batch appears only in the cycle after the second edge. The stall cycle between the two edges is sampled on its own and must show no grant. The bench drives inputs just after a rising edge and reads the grant at the falling edge. It then completes the granted slot at the next rising edge, so each expected grant in the queue is compared exactly one cycle apart from the previous one.

// File: rtl/sched_pkg.sv
package sched_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RANK = 2'd1,
      PH_RUN  = 2'd2
   } sched_phase_e;

   function automatic int width_of(input int n);
      int w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

endpackage

// File: rtl/batch_marker.sv
module batch_marker #(
   parameter int ENTRIES = 8,
   parameter int TID_W   = 2,
   parameter int BID_W   = 2,
   parameter int AGE_W   = 8,
   parameter int CAP_W   = 4,
   parameter int CNT_W   = 4
) (
   input  logic [ENTRIES-1:0]       pool_valid,
   input  logic [ENTRIES*TID_W-1:0] pool_thr,
   input  logic [ENTRIES*BID_W-1:0] pool_bank,
   input  logic [ENTRIES*AGE_W-1:0] pool_age,
   input  logic [CAP_W-1:0]         cap,
   output logic [ENTRIES-1:0]       mark_new
);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic [CNT_W-1:0] ahead;
      always_comb begin
         ahead = '0;
         for (int j = 0; j < ENTRIES; j++) begin
            if (j != i && pool_valid[j]
                && pool_thr[j*TID_W +: TID_W] == pool_thr[i*TID_W +: TID_W]
                && pool_bank[j*BID_W +: BID_W] == pool_bank[i*BID_W +: BID_W]
                && (pool_age[j*AGE_W +: AGE_W] > pool_age[i*AGE_W +: AGE_W]
                    || (pool_age[j*AGE_W +: AGE_W] == pool_age[i*AGE_W +: AGE_W] && j < i)))
               ahead = ahead + CNT_W'(1);
         end
      end
      assign mark_new[i] = pool_valid[i] && (32'(ahead) < 32'(cap));
   end

endmodule

// File: rtl/rank_table.sv
module rank_table #(
   parameter int ENTRIES = 8,
   parameter int THREADS = 4,
   parameter int BANKS   = 4,
   parameter int TID_W   = 2,
   parameter int BID_W   = 2,
   parameter int CNT_W   = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load_en,
   input  logic [ENTRIES-1:0]         marked,
   input  logic [ENTRIES*TID_W-1:0]   thr,
   input  logic [ENTRIES*BID_W-1:0]   bnk,
   output logic [THREADS*TID_W-1:0]   rank_q
);

   logic [CNT_W-1:0]         per_bank [THREADS][BANKS];
   logic [CNT_W-1:0]         peak     [THREADS];
   logic [CNT_W-1:0]         total    [THREADS];
   logic [THREADS*TID_W-1:0] rank_d;

   always_comb begin
      for (int t = 0; t < THREADS; t++)
         for (int b = 0; b < BANKS; b++)
            per_bank[t][b] = '0;
      for (int i = 0; i < ENTRIES; i++)
         for (int t = 0; t < THREADS; t++)
            for (int b = 0; b < BANKS; b++)
               if (marked[i] && thr[i*TID_W +: TID_W] == TID_W'(t)
                   && bnk[i*BID_W +: BID_W] == BID_W'(b))
                  per_bank[t][b] = per_bank[t][b] + CNT_W'(1);
   end

   always_comb begin
      for (int t = 0; t < THREADS; t++) begin
         peak[t]  = '0;
         total[t] = '0;
         for (int b = 0; b < BANKS; b++) begin
            total[t] = total[t] + per_bank[t][b];
            if (per_bank[t][b] > peak[t]) peak[t] = per_bank[t][b];
         end
      end
   end

   always_comb begin
      int ahead;
      rank_d = '0;
      for (int t = 0; t < THREADS; t++) begin
         ahead = 0;
         for (int u = 0; u < THREADS; u++) begin
            if (peak[u] < peak[t]
                || (peak[u] == peak[t] && total[u] < total[t])
                || (peak[u] == peak[t] && total[u] == total[t] && u < t))
               ahead++;
         end
         rank_d[t*TID_W +: TID_W] = TID_W'(ahead);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rank_q <= '0;
      else if (load_en) rank_q <= rank_d;
   end

endmodule

// File: rtl/grant_picker.sv
module grant_picker #(
   parameter int ENTRIES = 8,
   parameter int THREADS = 4,
   parameter int TID_W   = 2,
   parameter int AGE_W   = 8,
   parameter int IDX_W   = 3
) (
   input  logic [ENTRIES-1:0]       cand,
   input  logic [ENTRIES-1:0]       marked,
   input  logic [ENTRIES-1:0]       rowhit,
   input  logic [ENTRIES*TID_W-1:0] thr,
   input  logic [ENTRIES*AGE_W-1:0] age,
   input  logic [THREADS*TID_W-1:0] rank_tab,
   output logic                     pick_valid,
   output logic [IDX_W-1:0]         pick_idx
);

   localparam int KEY_W = 2 + TID_W + AGE_W;

   logic [KEY_W-1:0] key [ENTRIES];
   logic [KEY_W-1:0] best;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_key
      logic [TID_W-1:0] own_rank;
      always_comb begin
         own_rank = '0;
         for (int t = 0; t < THREADS; t++)
            if (thr[i*TID_W +: TID_W] == TID_W'(t))
               own_rank = rank_tab[t*TID_W +: TID_W];
      end
      assign key[i] = {marked[i], rowhit[i], ~own_rank, age[i*AGE_W +: AGE_W]};
   end

   always_comb begin
      pick_valid = 1'b0;
      pick_idx   = '0;
      best       = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (cand[i] && (!pick_valid || key[i] > best)) begin
            pick_valid = 1'b1;
            pick_idx   = IDX_W'(i);
            best       = key[i];
         end
      end
   end

endmodule

// File: rtl/batch_rank_sched.sv
module batch_rank_sched
   import sched_pkg::*;
#(
   parameter int ENTRIES         = 8,
   parameter int THREADS         = 4,
   parameter int BANKS           = 4,
   parameter int AGE_W           = 8,
   parameter int CAP_W           = 4,
   parameter bit OLDER_IS_LARGER = 1'b1
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [ENTRIES-1:0]                   ent_valid,
   input  logic [ENTRIES*$clog2(THREADS)-1:0]   ent_thread,
   input  logic [ENTRIES*$clog2(BANKS)-1:0]     ent_bank,
   input  logic [ENTRIES-1:0]                   ent_rowhit,
   input  logic [ENTRIES-1:0]                   ent_legal,
   input  logic [ENTRIES*AGE_W-1:0]             ent_age,
   input  logic [CAP_W-1:0]                     mark_cap,
   input  logic                                 done_valid,
   input  logic [$clog2(ENTRIES)-1:0]           done_idx,
   output logic                                 grant_valid,
   output logic [$clog2(ENTRIES)-1:0]           grant_idx
);

   localparam int TID_W = $clog2(THREADS);
   localparam int BID_W = $clog2(BANKS);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int CNT_W = width_of(ENTRIES + 1);

   if (ENTRIES < 2) begin : g_chk_entries
      $error("batch_rank_sched: ENTRIES must be at least 2");
   end
   if (THREADS < 2) begin : g_chk_threads
      $error("batch_rank_sched: THREADS must be at least 2");
   end
   if (BANKS < 2) begin : g_chk_banks
      $error("batch_rank_sched: BANKS must be at least 2");
   end
   if (AGE_W < 1 || CAP_W < 1) begin : g_chk_widths
      $error("batch_rank_sched: AGE_W and CAP_W must be positive");
   end

   sched_phase_e             phase_q;
   logic [ENTRIES-1:0]       mark_q;
   logic [ENTRIES-1:0]       live_mark;
   logic [ENTRIES-1:0]       done_mask;
   logic [ENTRIES-1:0]       mark_new;
   logic [ENTRIES-1:0]       cand;
   logic [BANKS-1:0]         bank_busy;
   logic [ENTRIES*AGE_W-1:0] age_n;
   logic [THREADS*TID_W-1:0] rank_tab;
   logic                     no_marks;
   logic                     form_batch;
   logic                     rank_valid;

   // age normalisation: larger value always means older downstream
   if (OLDER_IS_LARGER) begin : g_age_direct
      assign age_n = ent_age;
   end else begin : g_age_invert
      assign age_n = ~ent_age;
   end

   always_comb begin
      for (int i = 0; i < ENTRIES; i++)
         done_mask[i] = done_valid && (done_idx == IDX_W'(i));
   end

   assign live_mark  = mark_q & ent_valid;
   assign no_marks   = ~|live_mark;
   assign form_batch = no_marks && |(ent_valid & ~done_mask);
   assign rank_valid = (phase_q == PH_RUN);

   always_comb begin
      bank_busy = '0;
      for (int i = 0; i < ENTRIES; i++)
         for (int b = 0; b < BANKS; b++)
            if (live_mark[i] && ent_bank[i*BID_W +: BID_W] == BID_W'(b))
               bank_busy[b] = 1'b1;
   end

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cand
      logic own_busy;
      always_comb begin
         own_busy = 1'b0;
         for (int b = 0; b < BANKS; b++)
            if (ent_bank[i*BID_W +: BID_W] == BID_W'(b))
               own_busy = bank_busy[b];
      end
      assign cand[i] = ent_valid[i] && ent_legal[i]
                       && (live_mark[i] ? rank_valid : !own_busy);
   end

   batch_marker #(
      .ENTRIES(ENTRIES), .TID_W(TID_W), .BID_W(BID_W),
      .AGE_W(AGE_W), .CAP_W(CAP_W), .CNT_W(CNT_W)
   ) u_marker (
      .pool_valid (ent_valid & ~done_mask),
      .pool_thr   (ent_thread),
      .pool_bank  (ent_bank),
      .pool_age   (age_n),
      .cap        (mark_cap),
      .mark_new   (mark_new)
   );

   rank_table #(
      .ENTRIES(ENTRIES), .THREADS(THREADS), .BANKS(BANKS),
      .TID_W(TID_W), .BID_W(BID_W), .CNT_W(CNT_W)
   ) u_rank (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (phase_q == PH_RANK),
      .marked  (live_mark),
      .thr     (ent_thread),
      .bnk     (ent_bank),
      .rank_q  (rank_tab)
   );

   grant_picker #(
      .ENTRIES(ENTRIES), .THREADS(THREADS), .TID_W(TID_W),
      .AGE_W(AGE_W), .IDX_W(IDX_W)
   ) u_pick (
      .cand       (cand),
      .marked     (live_mark),
      .rowhit     (ent_rowhit),
      .thr        (ent_thread),
      .age        (age_n),
      .rank_tab   (rank_tab),
      .pick_valid (grant_valid),
      .pick_idx   (grant_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mark_q  <= '0;
         phase_q <= PH_IDLE;
      end else if (form_batch) begin
         mark_q  <= mark_new;
         phase_q <= PH_RANK;
      end else begin
         mark_q <= live_mark & ~done_mask;
         if (no_marks)               phase_q <= PH_IDLE;
         else if (phase_q == PH_RANK) phase_q <= PH_RUN;
      end
   end

endmodule

// File: rtl/batch_rank_sched_chk.sv
module batch_rank_sched_chk #(
   parameter int ENTRIES = 8,
   parameter int BANKS   = 4,
   parameter int BID_W   = 2,
   parameter int IDX_W   = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [ENTRIES-1:0]       ent_valid,
   input logic [ENTRIES-1:0]       ent_legal,
   input logic [ENTRIES*BID_W-1:0] ent_bank,
   input logic                     done_valid,
   input logic [IDX_W-1:0]         done_idx,
   input logic                     grant_valid,
   input logic [IDX_W-1:0]         grant_idx,
   input logic [ENTRIES-1:0]       mark_q,
   input logic                     rank_valid
);

   logic [BANKS-1:0] busy;
   logic             any_live;

   always_comb begin
      busy = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (mark_q[i] && ent_valid[i])
            busy[ent_bank[i*BID_W +: BID_W]] = 1'b1;
   end
   assign any_live = |(mark_q & ent_valid);

   // R8: grants name only valid, legal slots
   a_r8_grant_legal: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> (ent_valid[grant_idx] && ent_legal[grant_idx]));

   // R7: a marked grant waits for the rank table
   a_r7_marked_waits_rank: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && mark_q[grant_idx]) |-> rank_valid);

   // R6: unmarked grants only to banks free of marked work
   a_r6_unmarked_free_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && !mark_q[grant_idx])
         |-> !busy[ent_bank[grant_idx*BID_W +: BID_W]]);

   // R3: no new marks while a batch is live
   a_r3_no_mark_midbatch: assert property (@(posedge clk) disable iff (!rst_n)
      any_live |=> ((mark_q & ~$past(mark_q)) == '0));

   // R9: completion clears the mark
   a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !mark_q[$past(done_idx)]);

endmodule

bind batch_rank_sched batch_rank_sched_chk #(
   .ENTRIES(ENTRIES), .BANKS(BANKS), .BID_W($clog2(BANKS)), .IDX_W($clog2(ENTRIES))
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ent_valid   (ent_valid),
   .ent_legal   (ent_legal),
   .ent_bank    (ent_bank),
   .done_valid  (done_valid),
   .done_idx    (done_idx),
   .grant_valid (grant_valid),
   .grant_idx   (grant_idx),
   .mark_q      (mark_q),
   .rank_valid  (rank_valid)
);

// File: tb/tb_batch_rank_sched.sv
module tb_batch_rank_sched;

   localparam int E  = 8;
   localparam int T  = 4;
   localparam int B  = 4;
   localparam int AW = 8;
   localparam int CW = 4;
   localparam int IW = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [E-1:0]    v, lg, rh;
   logic [1:0]      thr [E];
   logic [1:0]      bnk [E];
   logic [AW-1:0]   age [E];
   logic [E*2-1:0]  thr_f, bnk_f;
   logic [E*AW-1:0] age_f;
   logic [CW-1:0]   cap;
   logic            done_valid;
   logic [IW-1:0]   done_idx;
   logic            grant_valid;
   logic [IW-1:0]   grant_idx;

   int    nchk = 0;
   int    nfail = 0;
   int    cyc = 0;
   int    exp_q [$];
   string tag_q [$];

   always #5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < E; i++) begin
         thr_f[i*2 +: 2]   = thr[i];
         bnk_f[i*2 +: 2]   = bnk[i];
         age_f[i*AW +: AW] = age[i];
      end
   end

   batch_rank_sched #(.ENTRIES(E), .THREADS(T), .BANKS(B), .AGE_W(AW), .CAP_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .ent_valid(v), .ent_thread(thr_f), .ent_bank(bnk_f),
      .ent_rowhit(rh), .ent_legal(lg), .ent_age(age_f), .mark_cap(cap),
      .done_valid(done_valid), .done_idx(done_idx),
      .grant_valid(grant_valid), .grant_idx(grant_idx));

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         summary();
      end
   end

   // monitor: compare each grant with the scoreboard and complete the slot
   initial begin
      int    gi;
      int    ev;
      string tg;
      forever begin
         @(negedge clk);
         if (rst_n && grant_valid) begin
            gi = int'(grant_idx);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5 unexpected grant", gi, -1);
            end else begin
               ev = exp_q.pop_front();
               tg = tag_q.pop_front();
               chk(gi == ev, tg, gi, ev);
            end
            done_valid = 1'b1;
            done_idx   = grant_idx;
            @(posedge clk);
            #1;
            v[gi]      = 1'b0;
            done_valid = 1'b0;
         end
      end
   end

   task automatic expect_grant(input int idx, input string tag);
      exp_q.push_back(idx);
      tag_q.push_back(tag);
   endtask

   task automatic put(input int i, input int t, input int b, input int a, input bit r);
      v[i]   = 1'b1;
      lg[i]  = 1'b0;
      thr[i] = 2'(t);
      bnk[i] = 2'(b);
      age[i] = AW'(a);
      rh[i]  = r;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic drain(input string tag);
      int n;
      n = 0;
      while (exp_q.size() > 0 && n < 500) begin
         @(posedge clk);
         n++;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(exp_q.size() == 0 && !grant_valid, tag, int'(grant_valid) + exp_q.size(), 0);
   endtask

   initial begin
      v = '0; lg = '0; rh = '0; cap = '0;
      done_valid = 1'b0; done_idx = '0;
      for (int i = 0; i < E; i++) begin
         thr[i] = '0; bnk[i] = '0; age[i] = '0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!grant_valid, "R1 reset grant low", int'(grant_valid), 0);

      // Scenario A: all marked, rank by max-bank-load, thread-id tie, row hit first
      step();
      cap = 4'd7;
      put(0, 2, 0, 10, 0); put(1, 2, 1, 9, 0); put(2, 2, 0, 8, 0);
      put(3, 1, 2, 7, 0);  put(4, 0, 3, 20, 0); put(5, 1, 2, 6, 1);
      put(6, 3, 1, 30, 0);
      step();                          // formation edge
      lg = 8'hFF;
      @(negedge clk);
      chk(!grant_valid, "R7 stall before rank", int'(grant_valid), 0);
      expect_grant(5, "R5 row hit first");
      expect_grant(4, "R4 thread id tie t0 over t3");
      expect_grant(6, "R4 low max-bank-load t3");
      expect_grant(3, "R4 rank t1 over t2");
      expect_grant(0, "R5 oldest within t2");
      expect_grant(1, "R5 oldest within t2");
      expect_grant(2, "R4 same rank on every bank");
      drain("R8 A drained");

      // Scenario B: cap of one, unmarked work on a freed bank
      step();
      cap = 4'd1;
      lg = '0;
      put(0, 0, 0, 5, 0); put(1, 0, 0, 9, 0); put(2, 0, 0, 7, 0);
      put(3, 1, 1, 3, 0); put(4, 1, 0, 8, 0); put(5, 2, 2, 4, 1);
      step();
      lg = 8'hFF;
      expect_grant(5, "R5 marked row hit");
      expect_grant(1, "R2 oldest of t0 bank0 marked");
      expect_grant(4, "R4 total-load tie break");
      expect_grant(3, "R5 marked over unmarked");
      expect_grant(2, "R6 unmarked on free bank");
      expect_grant(0, "R2 marked in next batch");
      drain("R8 B drained");

      // Scenario C: arrival during a live batch stays unmarked
      step();
      cap = 4'd2;
      lg = '0;
      put(0, 0, 0, 5, 0); put(1, 0, 1, 4, 0);
      step();                          // formation edge
      put(2, 1, 0, 50, 1);
      lg = 8'hFF;
      @(negedge clk);
      chk(!grant_valid, "R7 stall, bank0 busy", int'(grant_valid), 0);
      expect_grant(0, "R3 newcomer not marked");
      expect_grant(1, "R3 marked before newcomer");
      expect_grant(2, "R3 newcomer after batch");
      drain("R8 C drained");

      // Scenario E: completion clears mark of a refilled slot; legality gating
      step();
      cap = 4'd7;
      lg = '0;
      put(0, 0, 0, 5, 0); put(1, 1, 1, 3, 0);
      step();                          // formation edge
      step();                          // rank edge
      done_valid = 1'b1;
      done_idx   = 3'd0;
      put(0, 0, 0, 1, 1);              // slot refilled, still valid
      step();
      done_valid = 1'b0;
      lg[1] = 1'b1;
      expect_grant(1, "R8 illegal slot skipped");
      drain("R8 illegal slot held");
      lg[0] = 1'b1;
      expect_grant(0, "R9 refilled slot unmarked");
      drain("R9 drained");

      summary();
   end

endmodule